// File: doc/BRIEF.md
# Receive Line and Framing Defect Detector

This block watches the receive side of a synchronous optical line interface and raises five alarm levels: loss of clock, loss of signal, out of frame, loss of frame and line alarm indication. A frame aligner elsewhere in the chip supplies a one-cycle boundary strobe, a flag that says whether the framing pattern was found at that boundary, and the three line-signal bits of the K2 overhead byte. The detector also sees the serial receive data, the receive bit clock, an active-low loss-of-signal pin from the optical module, and a free-running reference clock.

Each alarm has its own asymmetric rule for being raised and cleared. Out of frame, loss of frame and line AIS are counted in frame boundaries. Loss of signal is counted in bits, and its criterion depends on whether the block runs at the single base rate or in multi-rate mode. Loss of clock is timed in reference-clock cycles: the receive clock drives a toggle, and the toggle is synchronized into the reference domain. All rates and limits are parameters, so a bench can use short frames.

Top module: `rx_line_defect_mon`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, all five alarm outputs are 0.
- R2: `oof` rises after the OOF_FRAMES-th (default 4) consecutive frame strobe that has `frame_ok`=0. Any strobe with `frame_ok`=1 restarts this count.
- R3: `oof` falls only on a strobe with `frame_ok`=1 whose previous strobe also had `frame_ok`=1 and came exactly FRAME_BITS rx_clk cycles earlier. Good patterns at any other spacing leave `oof` set.
- R4: `lof` rises after LOF_FRAMES (default 8) consecutive strobes at which `oof` was already high. It falls after LOF_FRAMES consecutive strobes at which `oof` was low.
- R5: `lais` rises after AIS_FRAMES (default 5) consecutive strobes with `k2_tail`=3'b111. It falls after AIS_FRAMES consecutive strobes with any other value.
- R6: With `rate_sel`=0 (single rate), `los` rises on the rx_clk edge that samples the LOS_ZERO_BITS-th consecutive 0 on `rx_data`.
- R7: With `rate_sel`=0, `los` falls on a strobe with `frame_ok`=1 while the synchronized pin is high and no raise condition holds.
- R8: With `rate_sel`=1 (multi rate), `los` rises once FRAME_BITS consecutive equal bits (all 0 or all 1) have been seen. It falls on any bit that differs from the previous one while the synchronized pin is high.
- R9: `los_pin_n` passes through a two-stage synchronizer and takes effect from the third rx_clk edge after it changes. While it is low, `los` is raised in both modes.
- R10: `loc` rises after LOC_CYCLES reference cycles with no rx_clk edge seen in that domain. It falls within a few reference cycles once the clock resumes.
- R11: Frame, signal and AIS alarms change only on rx_clk edges, and frame alarms only on the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive bit clock |
| ref_clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| rx_data | input | 1 | Serial scrambled receive data |
| frame_strobe | input | 1 | One-cycle frame boundary marker |
| frame_ok | input | 1 | Framing pattern found at this boundary |
| k2_tail | input | 3 | Last three transmitted bits of K2 |
| los_pin_n | input | 1 | External loss-of-signal pin, active low, asynchronous |
| rate_sel | input | 1 | 0 single rate, 1 multi rate |
| loc | output | 1 | Loss of receive clock (reference domain) |
| los | output | 1 | Loss of signal |
| oof | output | 1 | Out of frame |
| lof | output | 1 | Loss of frame |
| lais | output | 1 | Line AIS |

## Verification
The assertions assume that `frame_strobe`, `frame_ok` and `k2_tail` are settled around the rx_clk edge that samples them, and that `los_pin_n` stays put for at least three receive cycles when it changes. The bench drives every input on the falling rx_clk edge. It changes the pin only at frame boundaries and holds it for a whole frame. The reference clock runs more than twice as fast as the receive clock, so toggle edges are never lost. The rate select changes only under reset.

// File: rtl/rxdef_pkg.sv
package rxdef_pkg;

    typedef logic [15:0] span_t;

    typedef enum logic {
        RATE_SINGLE = 1'b0,
        RATE_MULTI  = 1'b1
    } rate_e;

    typedef struct packed {
        logic los;
        logic oof;
        logic lof;
        logic lais;
    } rx_alarm_t;

    function automatic span_t span_sat_inc(span_t c, span_t lim);
        return (c >= lim) ? lim : span_t'(c + 16'd1);
    endfunction

endpackage

// File: rtl/frame_hyst.sv
module frame_hyst #(
    parameter int SET_N = 8,
    parameter int CLR_N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cond,
    output logic state
);
    localparam int MAXN = (SET_N > CLR_N) ? SET_N : CLR_N;
    localparam int CW   = $clog2(MAXN + 1);

    logic [CW-1:0] set_run, clr_run, set_nx, clr_nx;

    always_comb begin
        set_nx = set_run;
        clr_nx = clr_run;
        if (tick) begin
            if (cond) begin
                set_nx = (set_run >= CW'(SET_N)) ? set_run : CW'(set_run + 1'b1);
                clr_nx = '0;
            end else begin
                clr_nx = (clr_run >= CW'(CLR_N)) ? clr_run : CW'(clr_run + 1'b1);
                set_nx = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_run <= '0;
            clr_run <= '0;
            state   <= 1'b0;
        end else begin
            set_run <= set_nx;
            clr_run <= clr_nx;
            if (tick && cond && (set_nx == CW'(SET_N)))
                state <= 1'b1;
            else if (tick && !cond && (clr_nx == CW'(CLR_N)))
                state <= 1'b0;
        end
    end
endmodule

// File: rtl/oof_mon.sv
module oof_mon
    import rxdef_pkg::*;
#(
    parameter int FRAME_BITS = 6480,
    parameter int OOF_N      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic frame_ok,
    output logic oof
);
    localparam int    BW      = $clog2(OOF_N + 1);
    localparam span_t GAP_LIM = span_t'(FRAME_BITS + 1);

    span_t         gap;
    logic          prev_ok;
    logic [BW-1:0] bad_run, bad_nx;
    logic          exact_gap;

    always_comb begin
        bad_nx = bad_run;
        if (strobe)
            bad_nx = frame_ok ? '0 :
                     ((bad_run >= BW'(OOF_N)) ? bad_run : BW'(bad_run + 1'b1));
    end

    assign exact_gap = prev_ok && (gap == span_t'(FRAME_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= '0;
            prev_ok <= 1'b0;
            bad_run <= '0;
            oof     <= 1'b0;
        end else begin
            bad_run <= bad_nx;
            if (strobe) begin
                gap     <= span_t'(1);
                prev_ok <= frame_ok;
                if (!frame_ok && (bad_nx == BW'(OOF_N)))
                    oof <= 1'b1;
                else if (frame_ok && exact_gap)
                    oof <= 1'b0;
            end else begin
                gap <= span_sat_inc(gap, GAP_LIM);
            end
        end
    end
endmodule

// File: rtl/los_mon.sv
module los_mon
    import rxdef_pkg::*;
#(
    parameter int FRAME_BITS = 6480,
    parameter int ZERO_BITS  = 1037
) (
    input  logic  clk,
    input  logic  rst,
    input  rate_e mode,
    input  logic  data,
    input  logic  strobe,
    input  logic  frame_ok,
    input  logic  pin_n,
    output logic  los
);
    logic  pin_s1, pin_s2;
    logic  prev_d;
    span_t run, run_nx, limit;
    logic  raise, drop;

    always_ff @(posedge clk) begin
        pin_s1 <= pin_n;
        pin_s2 <= pin_s1;
    end

    always_comb begin
        limit = (mode == RATE_MULTI) ? span_t'(FRAME_BITS) : span_t'(ZERO_BITS);
        if (mode == RATE_MULTI)
            run_nx = (data == prev_d) ? span_sat_inc(run, limit) : span_t'(1);
        else
            run_nx = (!data) ? span_sat_inc(run, limit) : '0;
        raise = (run_nx >= limit) || !pin_s2;
        if (mode == RATE_MULTI)
            drop = (data != prev_d) && pin_s2;
        else
            drop = strobe && frame_ok && pin_s2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_d <= 1'b0;
            run    <= '0;
            los    <= 1'b0;
        end else begin
            prev_d <= data;
            run    <= run_nx;
            if (raise)
                los <= 1'b1;
            else if (drop)
                los <= 1'b0;
        end
    end
endmodule

// File: rtl/clk_loss_mon.sv
module clk_loss_mon
    import rxdef_pkg::*;
#(
    parameter int LOC_CYCLES = 10
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic rx_toggle,
    output logic loc
);
    logic  t_s1, t_s2, t_s3;
    logic  seen_edge;
    span_t idle, idle_nx;

    assign seen_edge = t_s2 ^ t_s3;
    assign idle_nx   = seen_edge ? '0 : span_sat_inc(idle, span_t'(LOC_CYCLES));

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            t_s1 <= 1'b0;
            t_s2 <= 1'b0;
            t_s3 <= 1'b0;
            idle <= '0;
            loc  <= 1'b0;
        end else begin
            t_s1 <= rx_toggle;
            t_s2 <= t_s1;
            t_s3 <= t_s2;
            idle <= idle_nx;
            if (seen_edge)
                loc <= 1'b0;
            else if (idle_nx >= span_t'(LOC_CYCLES))
                loc <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_line_defect_mon.sv
module rx_line_defect_mon
    import rxdef_pkg::*;
#(
    parameter int FRAME_BITS    = 6480,
    parameter int LOS_ZERO_BITS = 1037,
    parameter int LOC_CYCLES    = 10,
    parameter int OOF_FRAMES    = 4,
    parameter int LOF_FRAMES    = 8,
    parameter int AIS_FRAMES    = 5
) (
    input  logic       rx_clk,
    input  logic       ref_clk,
    input  logic       rst,
    input  logic       rx_data,
    input  logic       frame_strobe,
    input  logic       frame_ok,
    input  logic [2:0] k2_tail,
    input  logic       los_pin_n,
    input  logic       rate_sel,
    output logic       loc,
    output logic       los,
    output logic       oof,
    output logic       lof,
    output logic       lais
);
    localparam logic [2:0] AIS_CODE = 3'b111;

    rx_alarm_t alm;
    logic      rx_toggle;
    logic      ais_code_seen;

    assign ais_code_seen = (k2_tail == AIS_CODE);

    always_ff @(posedge rx_clk) begin
        if (rst) rx_toggle <= 1'b0;
        else     rx_toggle <= ~rx_toggle;
    end

    oof_mon #(.FRAME_BITS(FRAME_BITS), .OOF_N(OOF_FRAMES)) oof_i (
        .clk(rx_clk), .rst(rst), .strobe(frame_strobe),
        .frame_ok(frame_ok), .oof(alm.oof)
    );

    frame_hyst #(.SET_N(LOF_FRAMES), .CLR_N(LOF_FRAMES)) lof_i (
        .clk(rx_clk), .rst(rst), .tick(frame_strobe),
        .cond(alm.oof), .state(alm.lof)
    );

    frame_hyst #(.SET_N(AIS_FRAMES), .CLR_N(AIS_FRAMES)) ais_i (
        .clk(rx_clk), .rst(rst), .tick(frame_strobe),
        .cond(ais_code_seen), .state(alm.lais)
    );

    los_mon #(.FRAME_BITS(FRAME_BITS), .ZERO_BITS(LOS_ZERO_BITS)) los_i (
        .clk(rx_clk), .rst(rst), .mode(rate_e'(rate_sel)), .data(rx_data),
        .strobe(frame_strobe), .frame_ok(frame_ok), .pin_n(los_pin_n),
        .los(alm.los)
    );

    clk_loss_mon #(.LOC_CYCLES(LOC_CYCLES)) loc_i (
        .ref_clk(ref_clk), .rst(rst), .rx_toggle(rx_toggle), .loc(loc)
    );

    assign los  = alm.los;
    assign oof  = alm.oof;
    assign lof  = alm.lof;
    assign lais = alm.lais;
endmodule

// File: rtl/rx_line_defect_chk.sv
module rx_line_defect_chk (
    input logic rx_clk,
    input logic rst,
    input logic frame_strobe,
    input logic frame_ok,
    input logic los_pin_n,
    input logic oof,
    input logic lof,
    input logic lais,
    input logic los
);
    a_r2_oof_rise_on_bad_strobe: assert property (@(posedge rx_clk) disable iff (rst)
        $rose(oof) |-> ($past(frame_strobe) && !$past(frame_ok)));

    a_r3_oof_fall_on_good_strobe: assert property (@(posedge rx_clk) disable iff (rst)
        $fell(oof) |-> ($past(frame_strobe) && $past(frame_ok)));

    a_r4_lof_rise_needs_oof: assert property (@(posedge rx_clk) disable iff (rst)
        $rose(lof) |-> ($past(frame_strobe) && $past(oof)));

    a_r4_lof_fall_needs_inframe: assert property (@(posedge rx_clk) disable iff (rst)
        $fell(lof) |-> ($past(frame_strobe) && !$past(oof)));

    a_r11_lais_moves_after_strobe: assert property (@(posedge rx_clk) disable iff (rst)
        !$stable(lais) |-> $past(frame_strobe));

    a_r9_pin_low_forces_los: assert property (@(posedge rx_clk) disable iff (rst)
        (!los_pin_n && !$past(los_pin_n) && !$past(los_pin_n, 2)) |=> los);
endmodule

bind rx_line_defect_mon rx_line_defect_chk chk_i (
    .rx_clk(rx_clk), .rst(rst), .frame_strobe(frame_strobe),
    .frame_ok(frame_ok), .los_pin_n(los_pin_n), .oof(oof), .lof(lof),
    .lais(lais), .los(los)
);

// File: tb/rx_line_defect_mon_tb_top.sv
module rx_line_defect_mon_tb_top;
    localparam int FB   = 48;
    localparam int LZ   = 20;
    localparam int LOCC = 10;

    logic ref_clk = 1'b0;
    logic rx_clk  = 1'b0;
    logic rx_run  = 1'b1;
    logic rst = 1'b1, rx_data = 1'b0, frame_strobe = 1'b0, frame_ok = 1'b0;
    logic [2:0] k2_tail = 3'b000;
    logic los_pin_n = 1'b1, rate_sel = 1'b0;
    logic loc, los, oof, lof, lais;

    int checks = 0, fails = 0;

    // model state
    int  m_bad, m_lof_set, m_lof_clr, m_ais_set, m_ais_clr, m_run, m_prev_len;
    bit  m_oof, m_lof, m_lais, m_los, m_prev_ok, m_prev_d, h1, h2;

    rx_line_defect_mon #(.FRAME_BITS(FB), .LOS_ZERO_BITS(LZ), .LOC_CYCLES(LOCC)) dut_i (
        .rx_clk(rx_clk), .ref_clk(ref_clk), .rst(rst), .rx_data(rx_data),
        .frame_strobe(frame_strobe), .frame_ok(frame_ok), .k2_tail(k2_tail),
        .los_pin_n(los_pin_n), .rate_sel(rate_sel), .loc(loc), .los(los),
        .oof(oof), .lof(lof), .lais(lais)
    );

    always #10 ref_clk = ~ref_clk;
    always begin
        #26;
        if (rx_run) rx_clk = ~rx_clk;
    end

    function automatic int sat(int v, int lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

    function automatic bit pat_bit(int pat, int i);
        case (pat)
            1: return 1'b0;
            2: return 1'b1;
            3: return (i % 2) == 0;
            default: return 1'($urandom % 2);
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_bad = 0; m_lof_set = 0; m_lof_clr = 0; m_ais_set = 0; m_ais_clr = 0;
        m_run = 0; m_prev_len = 0;
        m_oof = 0; m_lof = 0; m_lais = 0; m_los = 0; m_prev_ok = 0; m_prev_d = 0;
        h1 = 1; h2 = 1;
    endtask

    task automatic do_reset(input bit multi);
        rst = 1'b1; rate_sel = multi; frame_strobe = 0; rx_data = 0; los_pin_n = 1;
        repeat (4) @(posedge rx_clk);
        @(negedge rx_clk);
        rst = 1'b0;
        model_reset();
        #1;
        check(los, 0, "R1 los"); check(oof, 0, "R1 oof"); check(lof, 0, "R1 lof");
        check(lais, 0, "R1 lais"); check(loc, 0, "R1 loc");
    endtask

    task automatic frame_model(input bit ok, input logic [2:0] k2);
        bit old_oof = m_oof;
        if (!ok) begin
            m_bad = sat(m_bad, 4);
            if (m_bad >= 4) m_oof = 1;
        end else begin
            m_bad = 0;
            if (m_prev_ok && m_prev_len == FB) m_oof = 0;
        end
        m_prev_ok = ok;
        if (old_oof) begin
            m_lof_clr = 0; m_lof_set = sat(m_lof_set, 8);
            if (m_lof_set == 8) m_lof = 1;
        end else begin
            m_lof_set = 0; m_lof_clr = sat(m_lof_clr, 8);
            if (m_lof_clr == 8) m_lof = 0;
        end
        if (k2 == 3'b111) begin
            m_ais_clr = 0; m_ais_set = sat(m_ais_set, 5);
            if (m_ais_set == 5) m_lais = 1;
        end else begin
            m_ais_set = 0; m_ais_clr = sat(m_ais_clr, 5);
            if (m_ais_clr == 5) m_lais = 0;
        end
    endtask

    task automatic bit_model(input bit d, input bit s, input bit ok, input bit pin);
        bit eff = h2;
        bit setc, clrc;
        h2 = h1; h1 = pin;
        if (rate_sel) begin
            m_run = (d == m_prev_d) ? sat(m_run, FB) : 1;
            setc  = (m_run >= FB) || !eff;
            clrc  = (d != m_prev_d) && eff;
        end else begin
            m_run = (!d) ? sat(m_run, LZ) : 0;
            setc  = (m_run >= LZ) || !eff;
            clrc  = s && ok && eff;
        end
        m_prev_d = d;
        if (setc) m_los = 1; else if (clrc) m_los = 0;
    endtask

    task automatic send_frame(input int len, input bit ok, input logic [2:0] k2,
                              input int pat, input bit pin);
        for (int i = 0; i < len; i++) begin
            bit d = pat_bit(pat, i);
            @(negedge rx_clk);
            rx_data = d; frame_strobe = (i == 0); frame_ok = ok;
            k2_tail = k2; los_pin_n = pin;
            if (i == 0) frame_model(ok, k2);
            bit_model(d, i == 0, ok, pin);
        end
        m_prev_len = len;
        @(posedge rx_clk);
        #2;
        check(oof, m_oof, "R2 R3 oof");
        check(lof, m_lof, "R4 lof");
        check(lais, m_lais, "R5 lais");
        check(los, m_los, rate_sel ? "R8 R9 los" : "R6 R7 R9 los");
    endtask

    task automatic random_frames(input int n);
        bit bad_mode = 0, ais_mode = 0;
        for (int f = 0; f < n; f++) begin
            int len, pat;
            bit ok, pin;
            logic [2:0] k2;
            if ($urandom % 8 == 0) bad_mode = !bad_mode;
            if ($urandom % 7 == 0) ais_mode = !ais_mode;
            ok  = bad_mode ? ($urandom % 6 == 0) : ($urandom % 10 != 0);
            k2  = ais_mode ? 3'b111 : 3'($urandom);
            pat = $urandom % 8;
            if (pat == 4) pat = 1; else if (pat == 5) pat = 2;
            else if (pat > 5) pat = 3; else pat = 0;
            pin = ($urandom % 16 != 0);
            len = ($urandom % 12 == 0) ? FB + 1 : (($urandom % 12 == 0) ? FB - 1 : FB);
            send_frame(len, ok, k2, pat, pin);
        end
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd1357);
        // ---------- single-rate mode ----------
        do_reset(1'b0);
        repeat (3) send_frame(FB, 0, 3'b000, 3, 1);
        check(oof, 0, "R2 three bad frames keep oof low");
        send_frame(FB, 0, 3'b000, 3, 1);
        check(oof, 1, "R2 fourth bad frame raises oof");
        send_frame(FB + 1, 1, 3'b000, 3, 1);
        send_frame(FB, 1, 3'b000, 3, 1);
        check(oof, 1, "R3 good pattern off spacing keeps oof");
        send_frame(FB, 1, 3'b000, 3, 1);
        check(oof, 0, "R3 exact spacing clears oof");
        repeat (12) send_frame(FB, 0, 3'b000, 3, 1);
        check(lof, 1, "R4 lof after long out-of-frame");
        repeat (4) send_frame(FB, 0, 3'b111, 3, 1);
        check(lais, 0, "R5 four AIS frames not enough");
        send_frame(FB, 1, 3'b111, 3, 1);
        check(lais, 1, "R5 fifth AIS frame raises lais");
        send_frame(FB, 1, 3'b000, 1, 1);
        check(los, 1, "R6 zero run raises los");
        send_frame(FB, 1, 3'b000, 3, 1);
        check(los, 0, "R7 good frame with pin high clears los");
        send_frame(FB, 1, 3'b000, 3, 0);
        check(los, 1, "R9 pin low raises los");
        random_frames(140);
        // ---------- multi-rate mode ----------
        do_reset(1'b1);
        send_frame(FB, 1, 3'b000, 2, 1);
        send_frame(FB, 1, 3'b000, 2, 1);
        check(los, 1, "R8 run of ones raises los");
        send_frame(FB, 0, 3'b000, 3, 1);
        check(los, 0, "R8 transition clears los");
        random_frames(100);
        // ---------- loss of clock ----------
        repeat (6) @(negedge ref_clk);
        check(loc, 0, "R10 running clock keeps loc low");
        @(negedge rx_clk);
        rx_run = 1'b0;
        repeat (LOCC + 8) @(negedge ref_clk);
        check(loc, 1, "R10 stopped clock raises loc");
        rx_run = 1'b1;
        repeat (10) @(negedge ref_clk);
        check(loc, 0, "R10 resumed clock clears loc");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge ref_clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule